// File: doc/BRIEF.md
# Time-Shared Multichannel Incremental PID Controller

This block closes the control loop for several motor channels with a single arithmetic datapath. A sample strobe starts a sweep. The sweep visits the channels in ascending order, starting at channel 0. For each channel the sequencer loads the channel's stored context into working registers: the two previous errors, the previous output and the three gains. It then forms the error from the channel's setpoint and feedback inputs and evaluates the velocity form of the PID law. The result is saturated and written back to the context store, which also drives that channel's output.

All three products go through one signed multiplier. All four additions go through one adder. Each channel update therefore costs a fixed number of clock cycles. A done pulse marks the end of a sweep. A gain-load port fills each channel's three coefficients while the controller is idle. Common lower and upper output limits bound every channel.

Top module: `pid_mc_top`

## Requirements
- R1: The update for one channel is computed as follows, with DW = 16 and SHIFT = 8 by default. The error is e = setpoint − feedback, clamped to the signed DW-bit range. The increment is du = (q0·e + q1·e1 + q2·e2) >>> SHIFT, an arithmetic shift that rounds toward minus infinity. The new output is u = u_prev + du.
- R2: The new output is clamped to the range [lim_lo_i, lim_hi_i]. The clamped value becomes u_prev for the next update, so the output does not wind up past the limits.
- R3: Each channel keeps its own context. After an update the channel's e2 takes the old e1 and its e1 takes the new e. No other channel's context or output changes.
- R4: When a channel's current error and both stored errors are zero, its output is unchanged by the update.
- R5: A sample_i seen while idle starts a sweep over channels 0 to N_CH−1. busy_o is high for the whole sweep. done_o is a single-cycle pulse that first shows after exactly 8·N_CH rising edges, counted from the edge that took the strobe.
- R6: A sample_i seen during a sweep is ignored. overrun_o pulses high in the next cycle, and no extra sweep follows.
- R7: A write with gain_we_i high stores gain_data_i into gain q0, q1 or q2 of channel gain_ch_i, selected by gain_idx_i = 0, 1 or 2. The write is dropped when gain_idx_i = 3 or while busy_o is high.
- R8: Reset clears all stored errors, outputs and gains to zero, and drives busy_o, done_o and overrun_o low.
- R9: u_o changes only during a sweep. Between sweeps it holds, whatever the setpoint and feedback inputs do.
- R10: With q0 > 0 and q1 = q2 = 0, a positive error moves the output upward, toward the setpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe that starts a sweep |
| setpoint_i | input | N_CH*DW | Per-channel setpoints, signed; channel c at bits [c*DW +: DW] |
| feedback_i | input | N_CH*DW | Per-channel measured values, signed |
| lim_lo_i | input | DW | Lower output limit, signed |
| lim_hi_i | input | DW | Upper output limit, signed |
| gain_we_i | input | 1 | Gain write strobe |
| gain_ch_i | input | CHW | Channel to write |
| gain_idx_i | input | 2 | Gain select: 0 = q0, 1 = q1, 2 = q2, 3 = none |
| gain_data_i | input | DW | Signed gain value |
| u_o | output | N_CH*DW | Per-channel control outputs, signed |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse after the last channel is written |
| overrun_o | output | 1 | One-cycle pulse after a strobe that arrived while busy |

## Verification
Anti-windup is the hardest behaviour to reach from the ports. It shows only when an output has been held at a limit by a large error and the error then reverses. The next value must then start from the stored clamped value, not from the unclamped sum. The stimulus narrows the limits, drives full-scale opposing setpoints and feedback so that both the error clamp and the output clamp engage, and then reverses the error. The bench also raises a strobe and a maximal gain write in the middle of a sweep, to show that neither reaches the results.

// File: rtl/pid_pkg.sv
package pid_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOAD, ST_ERR, ST_MUL0, ST_MUL1, ST_MUL2, ST_ACC, ST_SAT, ST_STORE
  } state_t;

  localparam int unsigned CYC_PER_CH = 8;
  localparam logic [1:0] GIDX_Q0 = 2'd0;
  localparam logic [1:0] GIDX_Q1 = 2'd1;
  localparam logic [1:0] GIDX_Q2 = 2'd2;
endpackage

// File: rtl/pid_ctx.sv
module pid_ctx #(
  parameter int unsigned N_CH = 4,
  parameter int unsigned DW   = 16,
  localparam int unsigned CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     gain_we_i,
  input  logic [CHW-1:0]           gain_ch_i,
  input  logic [1:0]               gain_idx_i,
  input  logic signed [DW-1:0]     gain_data_i,
  input  logic [CHW-1:0]           rd_ch_i,
  output logic signed [DW-1:0]     rd_e1_o,
  output logic signed [DW-1:0]     rd_e2_o,
  output logic signed [DW-1:0]     rd_u_o,
  output logic signed [DW-1:0]     rd_q0_o,
  output logic signed [DW-1:0]     rd_q1_o,
  output logic signed [DW-1:0]     rd_q2_o,
  input  logic                     wb_we_i,
  input  logic [CHW-1:0]           wb_ch_i,
  input  logic signed [DW-1:0]     wb_e1_i,
  input  logic signed [DW-1:0]     wb_e2_i,
  input  logic signed [DW-1:0]     wb_u_i,
  output logic [N_CH*DW-1:0]       u_all_o,
  output logic [3*N_CH*DW-1:0]     gain_all_o
);
  import pid_pkg::*;

  logic signed [DW-1:0] e1_q [N_CH];
  logic signed [DW-1:0] e2_q [N_CH];
  logic signed [DW-1:0] u_q  [N_CH];
  logic signed [DW-1:0] q0_q [N_CH];
  logic signed [DW-1:0] q1_q [N_CH];
  logic signed [DW-1:0] q2_q [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic wb_hit, g_hit;
    assign wb_hit = wb_we_i && (wb_ch_i == CHW'(c));
    assign g_hit  = gain_we_i && (gain_ch_i == CHW'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        e1_q[c] <= '0;
        e2_q[c] <= '0;
        u_q[c]  <= '0;
      end else if (wb_hit) begin
        e1_q[c] <= wb_e1_i;
        e2_q[c] <= wb_e2_i;
        u_q[c]  <= wb_u_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q0_q[c] <= '0;
        q1_q[c] <= '0;
        q2_q[c] <= '0;
      end else if (g_hit) begin
        if (gain_idx_i == GIDX_Q0) q0_q[c] <= gain_data_i;
        if (gain_idx_i == GIDX_Q1) q1_q[c] <= gain_data_i;
        if (gain_idx_i == GIDX_Q2) q2_q[c] <= gain_data_i;
      end
    end

    assign u_all_o[c*DW +: DW]           = u_q[c];
    assign gain_all_o[(3*c)*DW +: DW]    = q0_q[c];
    assign gain_all_o[(3*c+1)*DW +: DW]  = q1_q[c];
    assign gain_all_o[(3*c+2)*DW +: DW]  = q2_q[c];
  end

  assign rd_e1_o = e1_q[rd_ch_i];
  assign rd_e2_o = e2_q[rd_ch_i];
  assign rd_u_o  = u_q[rd_ch_i];
  assign rd_q0_o = q0_q[rd_ch_i];
  assign rd_q1_o = q1_q[rd_ch_i];
  assign rd_q2_o = q2_q[rd_ch_i];
endmodule

// File: rtl/pid_seq.sv
module pid_seq #(
  parameter int unsigned N_CH = 4,
  localparam int unsigned CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sample_i,
  output pid_pkg::state_t state_o,
  output logic [CHW-1:0]  ch_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            overrun_o
);
  import pid_pkg::*;

  state_t state_q, state_d;
  logic [CHW-1:0] ch_q;
  logic last_ch;

  assign last_ch = (ch_q == CHW'(N_CH - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (sample_i) state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_ERR;
      ST_ERR:   state_d = ST_MUL0;
      ST_MUL0:  state_d = ST_MUL1;
      ST_MUL1:  state_d = ST_MUL2;
      ST_MUL2:  state_d = ST_ACC;
      ST_ACC:   state_d = ST_SAT;
      ST_SAT:   state_d = ST_STORE;
      ST_STORE: state_d = last_ch ? ST_IDLE : ST_LOAD;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ch_q      <= '0;
      done_o    <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      done_o    <= (state_q == ST_STORE) && last_ch;
      overrun_o <= sample_i && (state_q != ST_IDLE);
      if (state_q == ST_STORE) ch_q <= last_ch ? '0 : ch_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign ch_o    = ch_q;
  assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/pid_dp.sv
module pid_dp #(
  parameter int unsigned DW    = 16,
  parameter int unsigned SHIFT = 8,
  localparam int unsigned SW   = 2*DW + 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  pid_pkg::state_t      state_i,
  input  logic signed [DW-1:0] sp_i,
  input  logic signed [DW-1:0] fb_i,
  input  logic signed [DW-1:0] lim_lo_i,
  input  logic signed [DW-1:0] lim_hi_i,
  input  logic signed [DW-1:0] ctx_e1_i,
  input  logic signed [DW-1:0] ctx_e2_i,
  input  logic signed [DW-1:0] ctx_u_i,
  input  logic signed [DW-1:0] ctx_q0_i,
  input  logic signed [DW-1:0] ctx_q1_i,
  input  logic signed [DW-1:0] ctx_q2_i,
  output logic signed [DW-1:0] e_o,
  output logic signed [DW-1:0] e1_o,
  output logic signed [DW-1:0] e2_o,
  output logic signed [DW-1:0] uprev_o,
  output logic signed [SW-1:0] unew_o,
  output logic signed [DW-1:0] usat_o
);
  import pid_pkg::*;

  localparam logic signed [SW-1:0] DMAX = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] DMIN = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [DW-1:0] e_q, e1_q, e2_q, u_q, q0_q, q1_q, q2_q, us_q;
  logic signed [SW-1:0] acc_q, un_q;

  // shared multiplier
  logic signed [DW-1:0]   mul_a, mul_b;
  logic signed [2*DW-1:0] prod;
  logic signed [SW-1:0]   prod_w;

  always_comb begin
    unique case (state_i)
      ST_MUL1: begin mul_a = q1_q; mul_b = e1_q; end
      ST_MUL2: begin mul_a = q2_q; mul_b = e2_q; end
      default: begin mul_a = q0_q; mul_b = e_q;  end
    endcase
  end

  assign prod   = mul_a * mul_b;
  assign prod_w = {{(SW-2*DW){prod[2*DW-1]}}, prod};

  // shared adder with carry-in for subtraction
  logic signed [SW-1:0] add_a, add_b, add_sum;
  logic                 add_cin;

  always_comb begin
    add_a   = '0;
    add_b   = '0;
    add_cin = 1'b0;
    unique case (state_i)
      ST_ERR: begin
        add_a   = {{(SW-DW){sp_i[DW-1]}}, sp_i};
        add_b   = ~{{(SW-DW){fb_i[DW-1]}}, fb_i};
        add_cin = 1'b1;
      end
      ST_MUL1, ST_MUL2: begin
        add_a = acc_q;
        add_b = prod_w;
      end
      ST_ACC: begin
        add_a = {{(SW-DW){u_q[DW-1]}}, u_q};
        add_b = acc_q >>> SHIFT;
      end
      default: ;
    endcase
  end

  assign add_sum = add_a + add_b + $signed({{(SW-1){1'b0}}, add_cin});

  logic signed [DW-1:0] err_clamped, out_clamped;
  logic signed [SW-1:0] lo_w, hi_w;

  assign lo_w = {{(SW-DW){lim_lo_i[DW-1]}}, lim_lo_i};
  assign hi_w = {{(SW-DW){lim_hi_i[DW-1]}}, lim_hi_i};

  always_comb begin
    if (add_sum > DMAX)      err_clamped = DMAX[DW-1:0];
    else if (add_sum < DMIN) err_clamped = DMIN[DW-1:0];
    else                     err_clamped = add_sum[DW-1:0];

    if (un_q > hi_w)         out_clamped = lim_hi_i;
    else if (un_q < lo_w)    out_clamped = lim_lo_i;
    else                     out_clamped = un_q[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q <= '0; e1_q <= '0; e2_q <= '0; u_q <= '0;
      q0_q <= '0; q1_q <= '0; q2_q <= '0;
      acc_q <= '0; un_q <= '0; us_q <= '0;
    end else begin
      unique case (state_i)
        ST_LOAD: begin
          e1_q <= ctx_e1_i; e2_q <= ctx_e2_i; u_q <= ctx_u_i;
          q0_q <= ctx_q0_i; q1_q <= ctx_q1_i; q2_q <= ctx_q2_i;
        end
        ST_ERR:           e_q   <= err_clamped;
        ST_MUL0:          acc_q <= prod_w;
        ST_MUL1, ST_MUL2: acc_q <= add_sum;
        ST_ACC:           un_q  <= add_sum;
        ST_SAT:           us_q  <= out_clamped;
        default: ;
      endcase
    end
  end

  assign e_o     = e_q;
  assign e1_o    = e1_q;
  assign e2_o    = e2_q;
  assign uprev_o = u_q;
  assign unew_o  = un_q;
  assign usat_o  = us_q;
endmodule

// File: rtl/pid_mc_top.sv
module pid_mc_top #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned DW    = 16,
  parameter int unsigned SHIFT = 8,
  localparam int unsigned CHW  = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned SW   = 2*DW + 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic [N_CH*DW-1:0]   setpoint_i,
  input  logic [N_CH*DW-1:0]   feedback_i,
  input  logic signed [DW-1:0] lim_lo_i,
  input  logic signed [DW-1:0] lim_hi_i,
  input  logic                 gain_we_i,
  input  logic [CHW-1:0]       gain_ch_i,
  input  logic [1:0]           gain_idx_i,
  input  logic signed [DW-1:0] gain_data_i,
  output logic [N_CH*DW-1:0]   u_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 overrun_o
);
  import pid_pkg::*;

  state_t               state;
  logic [CHW-1:0]       ch;
  logic signed [DW-1:0] rd_e1, rd_e2, rd_u, rd_q0, rd_q1, rd_q2;
  logic signed [DW-1:0] e_w, e1_w, e2_w, uprev_w, usat_w;
  logic signed [SW-1:0] unew_w;
  logic signed [DW-1:0] sp_sel, fb_sel;
  logic [3*N_CH*DW-1:0] gain_all;

  pid_seq #(.N_CH(N_CH)) seq_i (
    .clk_i, .rst_ni, .sample_i,
    .state_o(state), .ch_o(ch), .busy_o, .done_o, .overrun_o
  );

  assign sp_sel = setpoint_i[ch*DW +: DW];
  assign fb_sel = feedback_i[ch*DW +: DW];

  pid_ctx #(.N_CH(N_CH), .DW(DW)) ctx_i (
    .clk_i, .rst_ni,
    .gain_we_i(gain_we_i && !busy_o), .gain_ch_i, .gain_idx_i, .gain_data_i,
    .rd_ch_i(ch),
    .rd_e1_o(rd_e1), .rd_e2_o(rd_e2), .rd_u_o(rd_u),
    .rd_q0_o(rd_q0), .rd_q1_o(rd_q1), .rd_q2_o(rd_q2),
    .wb_we_i(state == ST_STORE), .wb_ch_i(ch),
    .wb_e1_i(e_w), .wb_e2_i(e1_w), .wb_u_i(usat_w),
    .u_all_o(u_o), .gain_all_o(gain_all)
  );

  pid_dp #(.DW(DW), .SHIFT(SHIFT)) dp_i (
    .clk_i, .rst_ni, .state_i(state),
    .sp_i(sp_sel), .fb_i(fb_sel), .lim_lo_i, .lim_hi_i,
    .ctx_e1_i(rd_e1), .ctx_e2_i(rd_e2), .ctx_u_i(rd_u),
    .ctx_q0_i(rd_q0), .ctx_q1_i(rd_q1), .ctx_q2_i(rd_q2),
    .e_o(e_w), .e1_o(e1_w), .e2_o(e2_w), .uprev_o(uprev_w),
    .unew_o(unew_w), .usat_o(usat_w)
  );
endmodule

// File: rtl/pid_mc_chk.sv
module pid_mc_chk #(
  parameter int unsigned N_CH = 4,
  parameter int unsigned DW   = 16,
  parameter int unsigned SW   = 2*DW + 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sample_i,
  input logic                 gain_we_i,
  input logic signed [DW-1:0] lim_lo_i,
  input logic signed [DW-1:0] lim_hi_i,
  input logic [N_CH*DW-1:0]   u_o,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 overrun_o,
  input pid_pkg::state_t      state,
  input logic signed [DW-1:0] e_w,
  input logic signed [DW-1:0] e1_w,
  input logic signed [DW-1:0] e2_w,
  input logic signed [DW-1:0] uprev_w,
  input logic signed [SW-1:0] unew_w,
  input logic [3*N_CH*DW-1:0] gain_all
);
  import pid_pkg::*;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_AFTER_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state == ST_STORE)); // R5
  AST_OVERRUN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && busy_o) |=> overrun_o); // R6
  AST_GAIN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && gain_we_i) |=> $stable(gain_all)); // R7
  AST_OUT_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(u_o)); // R9
  AST_STABLE_ZERO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SAT && e_w == '0 && e1_w == '0 && e2_w == '0)
      |-> unew_w == {{(SW-DW){uprev_w[DW-1]}}, uprev_w}); // R4

  for (genvar c = 0; c < N_CH; c++) begin : g_lim
    AST_OUT_IN_LIMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ($signed(u_o[c*DW +: DW]) >= lim_lo_i &&
                  $signed(u_o[c*DW +: DW]) <= lim_hi_i)); // R2
  end
endmodule

bind pid_mc_top pid_mc_chk #(.N_CH(N_CH), .DW(DW), .SW(SW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .gain_we_i(gain_we_i),
  .lim_lo_i(lim_lo_i), .lim_hi_i(lim_hi_i), .u_o(u_o), .busy_o(busy_o),
  .done_o(done_o), .overrun_o(overrun_o), .state(state),
  .e_w(e_w), .e1_w(e1_w), .e2_w(e2_w), .uprev_w(uprev_w), .unew_w(unew_w),
  .gain_all(gain_all)
);

// File: tb/pid_mc_top_tb_top.sv
module pid_mc_top_tb_top;
  localparam int N_CH  = 4;
  localparam int DW    = 16;
  localparam int SHIFT = 8;
  localparam int CHW   = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_ni, sample_i, gain_we_i;
  logic [N_CH*DW-1:0]   setpoint_i, feedback_i, u_o;
  logic signed [DW-1:0] lim_lo_i, lim_hi_i, gain_data_i;
  logic [CHW-1:0]       gain_ch_i;
  logic [1:0]           gain_idx_i;
  logic                 busy_o, done_o, overrun_o;

  pid_mc_top #(.N_CH(N_CH), .DW(DW), .SHIFT(SHIFT)) dut_i (
    .clk_i(clk), .rst_ni, .sample_i, .setpoint_i, .feedback_i,
    .lim_lo_i, .lim_hi_i, .gain_we_i, .gain_ch_i, .gain_idx_i, .gain_data_i,
    .u_o, .busy_o, .done_o, .overrun_o
  );

  int n_chk = 0, n_fail = 0;
  longint m_e1[N_CH], m_e2[N_CH], m_u[N_CH], m_q[N_CH][3];
  longint sp_m[N_CH], fb_m[N_CH];

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clampl(longint v, longint lo, longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic longint u_at(int c);
    return longint'($signed(u_o[c*DW +: DW]));
  endfunction

  task automatic model_sweep();
    for (int c = 0; c < N_CH; c++) begin
      longint e, acc, un;
      e   = clampl(sp_m[c] - fb_m[c], -32768, 32767);
      acc = m_q[c][0]*e + m_q[c][1]*m_e1[c] + m_q[c][2]*m_e2[c];
      un  = m_u[c] + (acc >>> SHIFT);
      m_u[c]  = clampl(un, longint'(lim_lo_i), longint'(lim_hi_i));
      m_e2[c] = m_e1[c];
      m_e1[c] = e;
    end
  endtask

  task automatic write_gain(int c, int idx, int val);
    @(negedge clk);
    gain_we_i = 1'b1; gain_ch_i = CHW'(c); gain_idx_i = 2'(idx);
    gain_data_i = DW'(val);
    @(negedge clk);
    gain_we_i = 1'b0;
    if (idx < 3) m_q[c][idx] = longint'($signed(DW'(val)));
  endtask

  task automatic apply_inputs();
    for (int c = 0; c < N_CH; c++) begin
      setpoint_i[c*DW +: DW] = DW'(sp_m[c]);
      feedback_i[c*DW +: DW] = DW'(fb_m[c]);
    end
  endtask

  // one sweep; ovr raises a strobe mid-sweep, poke tries a gain write mid-sweep
  task automatic sweep(string req, bit ovr, bit poke);
    int cnt = 0;
    bit seen = 0;
    apply_inputs();
    @(negedge clk);
    sample_i = 1'b1;
    @(negedge clk);
    while (!seen && cnt < 1000) begin
      sample_i  = (cnt == 3) && ovr;
      gain_we_i = (cnt == 3) && poke;
      gain_ch_i = '0; gain_idx_i = 2'd0; gain_data_i = 16'sh7fff;
      @(negedge clk);
      cnt++;
      if (cnt == 4 && ovr) chk(overrun_o == 1'b1, "R6 overrun flag", overrun_o, 1);
      if (cnt < 8*N_CH) begin
        if (!busy_o) chk(0, "R5 busy during sweep", busy_o, 1);
      end
      if (done_o) seen = 1;
    end
    sample_i = 1'b0; gain_we_i = 1'b0;
    chk(cnt == 8*N_CH, "R5 sweep latency", cnt, 8*N_CH);
    model_sweep();
    for (int c = 0; c < N_CH; c++) chk(u_at(c) == m_u[c], req, u_at(c), m_u[c]);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R5 done single pulse", done_o, 0);
    if (ovr) begin
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0, "R6 no second sweep", busy_o, 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint prev;
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; sample_i = 1'b0; gain_we_i = 1'b0;
    gain_ch_i = '0; gain_idx_i = '0; gain_data_i = '0;
    setpoint_i = '0; feedback_i = '0;
    lim_lo_i = -16'sd30000; lim_hi_i = 16'sd30000;
    for (int c = 0; c < N_CH; c++) begin
      m_e1[c] = 0; m_e2[c] = 0; m_u[c] = 0; sp_m[c] = 0; fb_m[c] = 0;
      for (int k = 0; k < 3; k++) m_q[c][k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(u_o == '0, "R8 outputs after reset", longint'(u_o), 0);
    chk(!busy_o && !done_o && !overrun_o, "R8 flags after reset", busy_o, 0);

    // R8 gains cleared: nonzero error gives no movement
    for (int c = 0; c < N_CH; c++) begin sp_m[c] = 100 + c; fb_m[c] = 0; end
    sweep("R8 gains zero after reset", 0, 0);
    for (int c = 0; c < N_CH; c++) begin sp_m[c] = 7; fb_m[c] = 7; end
    sweep("R3 history shift", 0, 0);
    sweep("R3 history shift", 0, 0);

    // program gains; idx 3 must be dropped (R7)
    for (int c = 0; c < N_CH; c++) begin
      write_gain(c, 0, 256 + 32*c);
      write_gain(c, 1, -64);
      write_gain(c, 2, 16);
      write_gain(c, 3, 12345);
    end
    // R4 zero error with zero history
    sweep("R4 stable at zero error", 0, 0);

    // R10 upward move with pure proportional gain on channel 1
    write_gain(1, 1, 0); write_gain(1, 2, 0);
    sp_m[1] = 500; fb_m[1] = 400;
    prev = u_at(1);
    sweep("R1 incremental update", 0, 0);
    chk(u_at(1) > prev, "R10 output moves toward setpoint", u_at(1), prev + 1);

    // R9 hold between sweeps
    prev = u_at(1);
    repeat (5) @(negedge clk);
    setpoint_i = '1; feedback_i = '0;
    repeat (5) @(negedge clk);
    chk(u_at(1) == prev, "R9 output held while idle", u_at(1), prev);

    // R6 overrun and R7 gain write while busy
    sp_m[0] = 300; fb_m[0] = -200;
    sweep("R6 result unaffected by overrun", 1, 1);
    sweep("R7 busy gain write ignored", 0, 1);

    // R2 saturation and anti-windup with clamped error
    lim_lo_i = -16'sd50; lim_hi_i = 16'sd50;
    for (int c = 0; c < N_CH; c++) begin sp_m[c] = 32767; fb_m[c] = -32768; end
    sweep("R2 clamp high", 0, 0);
    sweep("R2 clamp high", 0, 0);
    for (int c = 0; c < N_CH; c++) begin sp_m[c] = -10; fb_m[c] = 0; end
    sweep("R2 anti-windup release", 0, 0);
    for (int c = 0; c < N_CH; c++) begin sp_m[c] = -32768; fb_m[c] = 32767; end
    sweep("R2 clamp low", 0, 0);
    lim_lo_i = -16'sd30000; lim_hi_i = 16'sd30000;

    // constrained random
    for (int it = 0; it < 150; it++) begin
      if (it % 25 == 0) begin
        for (int c = 0; c < N_CH; c++)
          for (int k = 0; k < 3; k++)
            write_gain(c, k, int'($urandom_range(1024)) - 512);
      end
      if (it % 40 == 20) begin
        lim_lo_i = -DW'(int'($urandom_range(32000, 100)));
        lim_hi_i = DW'(int'($urandom_range(32000, 100)));
      end
      for (int c = 0; c < N_CH; c++) begin
        if ($urandom_range(3) == 0) begin
          sp_m[c] = longint'($signed(DW'($urandom)));
          fb_m[c] = longint'($signed(DW'($urandom)));
        end else begin
          sp_m[c] = int'($urandom_range(2000)) - 1000;
          fb_m[c] = sp_m[c] + int'($urandom_range(200)) - 100;
        end
      end
      sweep("R1,R3 random update", ($urandom_range(7) == 0), ($urandom_range(7) == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule